// File: doc/BRIEF.md
# Floating-Point Magnitude Comparator

This block ranks two binary floating-point operands held in the usual packed layout of sign, biased exponent and fraction. It orders them with a single unsigned integer compare of the exponent-and-fraction bits. It then corrects that result for sign-and-magnitude encoding: a negative pair has its order reversed, and a pair with mixed signs is decided by the sign bits alone. Four mutually exclusive flags come out: less-than, equal, greater-than and unordered. The unordered flag is raised whenever either operand is a NaN.

On top of the flags, a one-bit condition output answers a requested predicate (equal, less-than or less-or-equal) so that a branch unit can test it directly. The block is purely combinational. The exponent and fraction widths are parameters, and the defaults give the 32-bit single-precision format.

Top module: `fp_order_cond`

## Requirements
- R1: For every pair of operand words, exactly one of `lt_o`, `eq_o`, `gt_o`, `unord_o` is 1.
- R2: When both operands are non-NaN and have sign bit 0, the flags follow the unsigned order of the low `EXP_W+FRAC_W` bits, so a larger biased exponent ranks higher and, at equal exponents, a larger fraction ranks higher.
- R3: When both operands are non-NaN and have sign bit 1, the magnitude order is reversed: the operand with the larger magnitude is the lesser one.
- R4: When the sign bits differ and the operands are not both zeros, the operand with sign bit 1 is the lesser one, provided neither is NaN.
- R5: An operand with the all-ones exponent and a nonzero fraction is NaN. If either operand is NaN, `unord_o` is 1 and `lt_o`, `eq_o` and `gt_o` are 0.
- R6: Two zeros (all-zero exponent and fraction) compare equal whatever their sign bits.
- R7: Denormals (zero exponent, nonzero fraction) rank below every normal value of the same sign, and infinity (all-ones exponent, zero fraction) ranks beyond every finite value, with no special handling.
- R8: `cond_o` answers `pred_i`: the encoding 0 gives equal, 1 gives less-than, 2 gives less-or-equal, and 3 always gives 0.
- R9: With either operand a NaN, `cond_o` is 0 for every predicate.
- R10: With the default parameters, the word is 32 bits wide: sign at bit 31, the 8-bit exponent at bits 30..23 with bias 127, and the fraction at bits 22..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | EXP_W+FRAC_W+1 | First operand word |
| b_i | input | EXP_W+FRAC_W+1 | Second operand word |
| pred_i | input | 2 | Predicate for the condition output |
| lt_o | output | 1 | a is less than b |
| eq_o | output | 1 | a equals b |
| gt_o | output | 1 | a is greater than b |
| unord_o | output | 1 | At least one operand is NaN |
| cond_o | output | 1 | Requested predicate holds |

## Verification
The bench builds the main instance with a 3-bit exponent and a 2-bit fraction. With only 64 words, every ordered pair can be swept against all four predicate codes. That sweep reaches every pairing of zeros of either sign, denormals, normals, infinities and NaNs, and the expected order comes from the numeric value of each word, computed as a scaled integer. A second instance with the default widths is driven with hand-worked 32-bit values to pin down the field positions.

// File: rtl/fp_order_pkg.sv
package fp_order_pkg;
  typedef enum logic [1:0] {
    PRED_EQ   = 2'd0,
    PRED_LT   = 2'd1,
    PRED_LE   = 2'd2,
    PRED_NONE = 2'd3
  } pred_e;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
    logic un;
  } order_t;
endpackage

// File: rtl/fp_order_class.sv
module fp_order_class #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = EXP_W + FRAC_W + 1
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              sign_o,
  output logic              nan_o,
  output logic              zero_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  always_comb begin
    sign_o = word_i[WORD_W-1];
    exp_f  = word_i[WORD_W-2 -: EXP_W];
    frac_f = word_i[FRAC_W-1:0];
    nan_o  = (&exp_f) && (|frac_f);
    zero_o = ~|word_i[WORD_W-2:0];
  end
endmodule

// File: rtl/fp_order_mag.sv
module fp_order_mag #(
  parameter int MAG_W = 31
) (
  input  logic [MAG_W-1:0] mag_a_i,
  input  logic [MAG_W-1:0] mag_b_i,
  output logic             mlt_o,
  output logic             meq_o,
  output logic             mgt_o
);
  always_comb begin
    mlt_o = mag_a_i < mag_b_i;
    meq_o = mag_a_i == mag_b_i;
    mgt_o = mag_a_i > mag_b_i;
  end
endmodule

// File: rtl/fp_order_resolve.sv
module fp_order_resolve
  import fp_order_pkg::*;
(
  input  logic   sa_i,
  input  logic   sb_i,
  input  logic   nan_a_i,
  input  logic   nan_b_i,
  input  logic   zero_a_i,
  input  logic   zero_b_i,
  input  logic   mlt_i,
  input  logic   meq_i,
  input  logic   mgt_i,
  output order_t ord_o
);
  always_comb begin
    ord_o = '0;
    if (nan_a_i || nan_b_i) begin
      ord_o.un = 1'b1;
    end else if (zero_a_i && zero_b_i) begin
      ord_o.eq = 1'b1;
    end else if (sa_i != sb_i) begin
      ord_o.lt = sa_i;
      ord_o.gt = sb_i;
    end else if (!sa_i) begin
      ord_o.lt = mlt_i;
      ord_o.eq = meq_i;
      ord_o.gt = mgt_i;
    end else begin
      ord_o.lt = mgt_i;
      ord_o.eq = meq_i;
      ord_o.gt = mlt_i;
    end
  end

  always_comb begin
    if (!$isunknown({sa_i, sb_i, nan_a_i, nan_b_i, zero_a_i, zero_b_i, mlt_i, meq_i, mgt_i})) begin
      // R1
      r1_one_flag_chk: assert ($countones(ord_o) == 1);
      // R5
      r5_nan_unord_chk: assert (ord_o.un == (nan_a_i || nan_b_i));
      // R6
      r6_zero_eq_chk: assert (!(zero_a_i && zero_b_i) || ord_o.eq);
      // R4
      r4_sign_split_chk: assert (!(sa_i && !sb_i && !nan_a_i && !nan_b_i && !(zero_a_i && zero_b_i)) || ord_o.lt);
    end
  end
endmodule

// File: rtl/fp_order_cond.sv
module fp_order_cond
  import fp_order_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = EXP_W + FRAC_W + 1,
  localparam int MAG_W  = WORD_W - 1
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [1:0]        pred_i,
  output logic              lt_o,
  output logic              eq_o,
  output logic              gt_o,
  output logic              unord_o,
  output logic              cond_o
);
  logic   sa, sb, nan_a, nan_b, zero_a, zero_b;
  logic   mlt, meq, mgt;
  order_t ord;
  pred_e  pred;

  fp_order_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_class_a (
    .word_i(a_i), .sign_o(sa), .nan_o(nan_a), .zero_o(zero_a));

  fp_order_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_class_b (
    .word_i(b_i), .sign_o(sb), .nan_o(nan_b), .zero_o(zero_b));

  fp_order_mag #(.MAG_W(MAG_W)) u_mag (
    .mag_a_i(a_i[MAG_W-1:0]), .mag_b_i(b_i[MAG_W-1:0]),
    .mlt_o(mlt), .meq_o(meq), .mgt_o(mgt));

  fp_order_resolve u_resolve (
    .sa_i(sa), .sb_i(sb), .nan_a_i(nan_a), .nan_b_i(nan_b),
    .zero_a_i(zero_a), .zero_b_i(zero_b),
    .mlt_i(mlt), .meq_i(meq), .mgt_i(mgt), .ord_o(ord));

  always_comb begin
    pred    = pred_e'(pred_i);
    lt_o    = ord.lt;
    eq_o    = ord.eq;
    gt_o    = ord.gt;
    unord_o = ord.un;
    unique case (pred)
      PRED_EQ: cond_o = ord.eq;
      PRED_LT: cond_o = ord.lt;
      PRED_LE: cond_o = ord.lt | ord.eq;
      default: cond_o = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, pred_i})) begin
      // R9
      r9_nan_cond_chk: assert (!unord_o || !cond_o);
      // R8
      r8_le_cond_chk: assert (pred_i != 2'd2 || cond_o == (lt_o || eq_o));
      // R8
      r8_none_cond_chk: assert (pred_i != 2'd3 || !cond_o);
    end
  end
endmodule

// File: tb/fp_order_cond_bench.sv
module fp_order_cond_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SE = 3;
  localparam int SF = 2;
  localparam int SW = SE + SF + 1;
  localparam int NWORD = 1 << SW;

  logic clk = 1'b0;
  logic rst_n;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [SW-1:0] a, b;
  logic [1:0]    pred;
  logic lt, eq, gt, un, cond;

  fp_order_cond #(.EXP_W(SE), .FRAC_W(SF)) u_fp_order_cond (
    .a_i(a), .b_i(b), .pred_i(pred),
    .lt_o(lt), .eq_o(eq), .gt_o(gt), .unord_o(un), .cond_o(cond));

  logic [31:0] sa32, sb32;
  logic [1:0]  sp_pred;
  logic slt, seq, sgt, sun, scond;

  fp_order_cond u_fp_order_cond_sp (
    .a_i(sa32), .b_i(sb32), .pred_i(sp_pred),
    .lt_o(slt), .eq_o(seq), .gt_o(sgt), .unord_o(sun), .cond_o(scond));

  function automatic bit is_nan(input logic [SW-1:0] w);
    return (w[SW-2 -: SE] == {SE{1'b1}}) && (w[SF-1:0] != '0);
  endfunction

  function automatic int value_of(input logic [SW-1:0] w);
    int e, f, v;
    e = int'(w[SW-2 -: SE]);
    f = int'(w[SF-1:0]);
    if (e == (1 << SE) - 1) v = 100000;
    else if (e == 0) v = f;
    else v = ((1 << SF) + f) << (e - 1);
    return w[SW-1] ? -v : v;
  endfunction

  task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h flags(lt,eq,gt,un) actual=%b expected=%b", tag, a, b, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h pred=%0d cond actual=%b expected=%b", tag, a, b, pred, act, exp);
    end
  endtask

  task automatic check_sp(input string tag, input logic [31:0] x, input logic [31:0] y,
                          input logic [1:0] p, input logic [4:0] exp);
    sa32 = x; sb32 = y; sp_pred = p;
    @(negedge clk);
    checks++;
    if ({slt, seq, sgt, sun, scond} !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h actual=%b expected=%b", tag, x, y, {slt, seq, sgt, sun, scond}, exp);
    end
    @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; pred = '0;
    sa32 = '0; sb32 = '0; sp_pred = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk);

    // Reset-time state: two +0 words, predicate equal (R6, R8)
    @(negedge clk);
    check4("R6", {lt, eq, gt, un}, 4'b0100);
    check1("R8", cond, 1'b1);

    for (int i = 0; i < NWORD; i++) begin
      for (int j = 0; j < NWORD; j++) begin
        for (int p = 0; p < 4; p++) begin
          logic [3:0] ex;
          logic       ec;
          string      tag;
          int         va, vb;
          bit         nn;
          @(posedge clk);
          a = i[SW-1:0]; b = j[SW-1:0]; pred = p[1:0];
          @(negedge clk);
          nn = is_nan(a) || is_nan(b);
          va = value_of(a); vb = value_of(b);
          if (nn) ex = 4'b0001;
          else if (va < vb) ex = 4'b1000;
          else if (va == vb) ex = 4'b0100;
          else ex = 4'b0010;
          case (p)
            0: ec = ex[2];
            1: ec = ex[3];
            2: ec = ex[3] | ex[2];
            default: ec = 1'b0;
          endcase
          if (nn) tag = "R5";
          else if (va == 0 && vb == 0) tag = "R6";
          else if (a[SW-1] != b[SW-1]) tag = "R4";
          else if (a[SW-2 -: SE] == 0 || b[SW-2 -: SE] == 0 ||
                   a[SW-2 -: SE] == {SE{1'b1}} || b[SW-2 -: SE] == {SE{1'b1}}) tag = "R7";
          else if (a[SW-1]) tag = "R3";
          else tag = "R2";
          if (p == 0) begin
            check4(tag, {lt, eq, gt, un}, ex);
            checks++;
            if ($countones({lt, eq, gt, un}) != 1) begin
              errors++;
              $display("FAIL R1 a=%h b=%h flags actual=%b expected=one hot", a, b, {lt, eq, gt, un});
            end
          end
          check1(nn ? "R9" : "R8", cond, ec);
        end
      end
    end

    @(posedge clk);
    // R10: -0.15625 vs 10.375, predicate less-than
    check_sp("R10", 32'hBE20_0000, 32'h4126_0000, 2'd1, 5'b10001);
    // R10: infinity vs largest finite, less-or-equal
    check_sp("R10", 32'h7F80_0000, 32'h7F7F_FFFF, 2'd2, 5'b00100);
    // R10: NaN vs 1.0, equal
    check_sp("R10", 32'h7FC0_0000, 32'h3F80_0000, 2'd0, 5'b00010);
    // R10: -0 vs +0, equal
    check_sp("R10", 32'h8000_0000, 32'h0000_0000, 2'd0, 5'b01001);
    // R10: -1.25*2^-3 vs -(1.0), both negative, greater
    check_sp("R10", 32'hBE20_0000, 32'hBF80_0000, 2'd1, 5'b00100);
    // R10: smallest normal vs largest denormal
    check_sp("R10", 32'h0080_0000, 32'h007F_FFFF, 2'd2, 5'b00100);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule